// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the processor-facing control plane of a simple byte-oriented UART. It decodes a 64-byte register window carried on a small synchronous bus (chip-select, write-enable, 6-bit address, 8-bit data, with read data returned combinationally in the same cycle). It holds the transmitter and receiver enables and two mode bytes. A four-entry receive queue is filled by the deserializer. The block hands each transmit byte to the serializer over a valid/ready handshake and drives one level-sensitive interrupt formed from masked interrupt status.

Software controls the block through a command byte that packs three independent fields: a miscellaneous action, a transmitter action and a receiver action. They are applied in that order, so one write can reset the receiver and re-enable it. Both mode bytes sit behind one address through a pointer that moves forward after each write. The receive interrupt source is either "queue not empty" or "queue full", chosen by a mode bit. A line break seen by the deserializer places a zero byte in the queue and raises a delta-break interrupt.

Top module: `uart_regctl`

## Requirements
- R1: Decode uses addr[5:0]. Read offsets: 0x00 mode (selected by pointer), 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 baud byte low, 0x1C baud byte high. Offsets 0x08, 0x10 and every other offset read 0.
- R2: One mode pointer selects mode byte 1 or 2 at offset 0x00. A write stores into the selected byte and then points to mode byte 2. Only misc command 1 returns the pointer to mode byte 1.
- R3: Status bits: bit0 receive data present, bit1 queue full (4 entries), bit2 transmit ready (equals transmitter enable), bit3 transmit empty. Bits 7:4 read 0.
- R4: After reset, status reads 0x08, both mode bytes, interrupt status and mask read 0, both enables are off, the queue is empty, and irq, tx_valid and rx_ready are low.
- R5: Interrupt status: bit0 equals transmit ready. Bit1 equals queue full when mode byte 1 bit 6 is set, and receive data present otherwise. Bit2 is the delta-break flag. All other bits read 0.
- R6: A write to 0x14 loads the mask. irq is high exactly when (interrupt status AND mask) is nonzero.
- R7: Command (write 0x08) bits [6:4]: 1 resets the mode pointer, 2 disables the receiver and empties the queue, 3 disables the transmitter, sets transmit empty and drops any pending byte, 5 clears delta-break. 0, 4, 6 and 7 have no effect.
- R8: Command bits [3:2] act on the transmitter and bits [1:0] on the receiver: 1 enables, 2 disables, 0 and 3 leave it unchanged. The misc field is applied first, then transmitter, then receiver.
- R9: Writing 0x0C latches the byte and clears transmit empty. tx_valid is high while the transmitter is enabled and transmit empty is clear. tx_data and tx_valid hold until tx_ready, and transmit empty sets on the accepting cycle.
- R10: rx_ready is high when the receiver is enabled and the queue is not full. A byte is queued on rx_valid and rx_ready. Reading 0x0C returns the oldest byte and removes it. Reading an empty queue returns 0.
- R11: An rx_break pulse queues 0x00 and sets delta-break whether or not the receiver is enabled. When the queue is full it replaces the newest entry. It takes precedence over an rx_valid in the same cycle.
- R12: Writes to 0x04 and 0x10 have no effect. Writes to 0x18 and 0x1C load the baud bytes, which read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte offset in the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can take a byte |
| rx_break | input | 1 | One-cycle line-break event |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- tx_data holds steady and tx_valid stays high until tx_ready.
- An accepted byte clears tx_valid.
- The receive queue never exceeds its depth, and a pop never happens on an empty queue.
- rx_ready is low while the queue is full.
- A mode write leaves the pointer on mode byte 2, and a receiver-reset command empties the queue.
- irq stays low while the mask is zero.

Only the directed scenarios can show the following:
- The register map and its read values.
- The three command fields applied in sequence.
- The receive-interrupt source chosen by the mode bit.
- The break byte overwriting the newest full entry.
- The byte order out of the queue.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_MODE   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_AUX    = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_INT    = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_BAUD_L = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_BAUD_H = 6'h1C;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_ACK = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_cmd_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_cmd_e;

  // Bit 6 of mode byte 1 picks the receive interrupt source
  localparam int MODE1_RXSEL_BIT = 6;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          brk,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_new, wr_ovw, mem_we;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_val;

  assign empty  = (count == '0);
  assign full   = (count == FULL_CNT);
  // A break byte always lands; when there is no room it replaces the newest entry
  assign wr_new = (push || brk) && (!full || pop);
  assign wr_ovw = brk && full && !pop;
  assign wr_val = brk ? '0 : push_data;
  assign wr_idx = wr_ovw ? (wr_ptr - AW'(1)) : wr_ptr;
  assign mem_we = (wr_new || wr_ovw) && !clr;

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_new) wr_ptr <= wr_ptr + AW'(1);
      if (pop)    rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(wr_new) - CW'(pop);
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          en,
  input  logic          drop,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          empty
);
  assign valid = en && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      data  <= '0;
    end else if (load) begin
      empty <= 1'b0;
      data  <= load_data;
    end else if (drop || (valid && ready)) begin
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int DW = 8
) (
  input  logic          tx_rdy,
  input  logic          rx_avail,
  input  logic          rx_full,
  input  logic          sel_full,
  input  logic          dbrk,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] isr,
  output logic          irq
);
  always_comb begin
    isr    = '0;
    isr[0] = tx_rdy;
    isr[1] = sel_full ? rx_full : rx_avail;
    isr[2] = dbrk;
  end

  assign irq = |(isr & mask);
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_ready,
  input  logic              rx_break,
  output logic              irq
);
  logic [DW-1:0] mode1, mode2, imr, baud_l, baud_h;
  logic          mr_ptr, tx_en, rx_en, dbrk;
  logic          bus_wr, bus_rd, cmd_wr;
  misc_cmd_e     misc;
  dir_cmd_e      txc, rxc;

  logic [DW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_empty, fifo_full, fifo_clr, rx_pop, rx_push;
  logic          tx_empty, tx_drop, tx_load;
  logic [DW-1:0] isr, status;

  assign bus_wr = cs && we;
  assign bus_rd = cs && !we;
  assign cmd_wr = bus_wr && (addr == OFF_CMD);
  assign misc   = misc_cmd_e'(wdata[6:4]);
  assign txc    = dir_cmd_e'(wdata[3:2]);
  assign rxc    = dir_cmd_e'(wdata[1:0]);

  assign fifo_clr = cmd_wr && (misc == MISC_RX_RST);
  assign tx_drop  = cmd_wr && (misc == MISC_TX_RST);
  assign tx_load  = bus_wr && (addr == OFF_DATA);
  assign rx_ready = rx_en && !fifo_full;
  assign rx_push  = rx_valid && rx_ready && !rx_break;
  assign rx_pop   = bus_rd && (addr == OFF_DATA) && !fifo_empty;

  // Register file and command sequencing: misc, then transmitter, then receiver
  always_ff @(posedge clk) begin
    if (rst) begin
      mode1  <= '0;
      mode2  <= '0;
      mr_ptr <= 1'b0;
      imr    <= '0;
      baud_l <= '0;
      baud_h <= '0;
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      dbrk   <= 1'b0;
    end else begin
      if (bus_wr) begin
        unique case (addr)
          OFF_MODE: begin
            if (mr_ptr) mode2 <= wdata;
            else        mode1 <= wdata;
            mr_ptr <= 1'b1;
          end
          OFF_INT:    imr    <= wdata;
          OFF_BAUD_L: baud_l <= wdata;
          OFF_BAUD_H: baud_h <= wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        case (misc)
          MISC_PTR_RST: mr_ptr <= 1'b0;
          MISC_RX_RST:  rx_en  <= 1'b0;
          MISC_TX_RST:  tx_en  <= 1'b0;
          MISC_BRK_ACK: dbrk   <= 1'b0;
          default: ;
        endcase
        case (txc)
          DIR_ON:  tx_en <= 1'b1;
          DIR_OFF: tx_en <= 1'b0;
          default: ;
        endcase
        case (rxc)
          DIR_ON:  rx_en <= 1'b1;
          DIR_OFF: rx_en <= 1'b0;
          default: ;
        endcase
      end
      // A new break event outranks an acknowledge in the same cycle
      if (rx_break) dbrk <= 1'b1;
    end
  end

  uart_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(rx_push), .push_data(rx_data), .brk(rx_break), .pop(rx_pop),
    .head(fifo_head), .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full)
  );

  uart_tx_stage #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .load_data(wdata),
    .en(tx_en), .drop(tx_drop), .ready(tx_ready),
    .valid(tx_valid), .data(tx_data), .empty(tx_empty)
  );

  uart_irq_unit #(.DW(DW)) u_irq (
    .tx_rdy(tx_en), .rx_avail(!fifo_empty), .rx_full(fifo_full),
    .sel_full(mode1[MODE1_RXSEL_BIT]), .dbrk(dbrk), .mask(imr),
    .isr(isr), .irq(irq)
  );

  always_comb begin
    status    = '0;
    status[0] = !fifo_empty;
    status[1] = fifo_full;
    status[2] = tx_en;
    status[3] = tx_empty;
  end

  always_comb begin
    rdata = '0;
    if (bus_rd) begin
      case (addr)
        OFF_MODE:   rdata = mr_ptr ? mode2 : mode1;
        OFF_STAT:   rdata = status;
        OFF_DATA:   rdata = fifo_empty ? '0 : fifo_head;
        OFF_INT:    rdata = isr;
        OFF_BAUD_L: rdata = baud_l;
        OFF_BAUD_H: rdata = baud_h;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          we,
  input logic [5:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_ready,
  input logic          tx_en,
  input logic          rx_ready,
  input logic          irq,
  input logic [DW-1:0] imr,
  input logic          mr_ptr,
  input logic          rx_pop,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full
);
  localparam logic [CW-1:0] MAX_CNT = CW'(DEPTH);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(cs && we)) |=> (tx_valid && $stable(tx_data)));

  assert_tx_done_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !(cs && we)) |=> !tx_valid);

  assert_tx_gated_R9: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_en);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= MAX_CNT);

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !rx_ready);

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (fifo_cnt != '0));

  assert_mode_ptr_R2: assert property (@(posedge clk) disable iff (rst)
    (cs && we && addr == 6'h00) |=> mr_ptr);

  assert_rx_reset_R7: assert property (@(posedge clk) disable iff (rst)
    (cs && we && addr == 6'h08 && wdata[6:4] == 3'd2) |=> (fifo_cnt == '0));

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (imr == '0) |-> !irq);
endmodule

bind uart_regctl uart_regctl_chk #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_en(tx_en),
  .rx_ready(rx_ready), .irq(irq), .imr(imr), .mr_ptr(mr_ptr),
  .rx_pop(rx_pop), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full)
);

// File: tb/tb_uart_regctl.sv
module tb_uart_regctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic       rx_break = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_regctl dut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_break(rx_break), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 chk(req, $sformatf("read %02h", a), rdata, exp);
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(6'h04, 8'h08, "R4");
    rd_chk(6'h00, 8'h00, "R4");
    rd_chk(6'h14, 8'h00, "R4");
    chk("R4", "irq", {7'd0, irq}, 8'h00);
    chk("R4", "tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R4", "rx_ready", {7'd0, rx_ready}, 8'h00);
  endtask

  task automatic t_mode_ptr();
    wr(6'h00, 8'h40);
    rd_chk(6'h00, 8'h00, "R2");
    wr(6'h00, 8'h13);
    rd_chk(6'h00, 8'h13, "R2");
    wr(6'h08, 8'h10);
    rd_chk(6'h00, 8'h40, "R2");
  endtask

  task automatic t_map();
    wr(6'h04, 8'hFF);
    wr(6'h10, 8'hFF);
    rd_chk(6'h04, 8'h08, "R12");
    rd_chk(6'h10, 8'h00, "R1");
    rd_chk(6'h08, 8'h00, "R1");
    rd_chk(6'h20, 8'h00, "R1");
    rd_chk(6'h3C, 8'h00, "R1");
    wr(6'h18, 8'hA5);
    wr(6'h1C, 8'h5A);
    rd_chk(6'h18, 8'hA5, "R12");
    rd_chk(6'h1C, 8'h5A, "R12");
    rd_chk(6'h00, 8'h40, "R12");
  endtask

  task automatic t_tx();
    wr(6'h08, 8'h04);
    rd_chk(6'h04, 8'h0C, "R3");
    rd_chk(6'h14, 8'h01, "R5");
    chk("R6", "irq unmasked", {7'd0, irq}, 8'h00);
    wr(6'h14, 8'h01);
    chk("R6", "irq masked in", {7'd0, irq}, 8'h01);
    wr(6'h0C, 8'h3C);
    chk("R9", "tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R9", "tx_data", tx_data, 8'h3C);
    rd_chk(6'h04, 8'h04, "R9");
    repeat (3) @(negedge clk);
    chk("R9", "tx held", {7'd0, tx_valid}, 8'h01);
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R9", "tx after accept", {7'd0, tx_valid}, 8'h00);
    rd_chk(6'h04, 8'h0C, "R9");
    wr(6'h08, 8'h08);
    rd_chk(6'h04, 8'h08, "R8");
    wr(6'h0C, 8'h77);
    chk("R9", "tx disabled", {7'd0, tx_valid}, 8'h00);
    rd_chk(6'h04, 8'h00, "R9");
    wr(6'h08, 8'h04);
    chk("R9", "tx_data pending", tx_data, 8'h77);
    chk("R9", "tx valid pending", {7'd0, tx_valid}, 8'h01);
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    wr(6'h08, 8'h08);
    wr(6'h0C, 8'h99);
    wr(6'h08, 8'h30);
    rd_chk(6'h04, 8'h08, "R7");
    wr(6'h08, 8'h34);
    rd_chk(6'h04, 8'h0C, "R8");
    chk("R7", "dropped byte", {7'd0, tx_valid}, 8'h00);
    wr(6'h14, 8'h00);
    chk("R6", "irq mask clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rx();
    rx_push(8'hEE);
    rd_chk(6'h04, 8'h0C, "R10");
    wr(6'h08, 8'h01);
    chk("R10", "rx_ready on", {7'd0, rx_ready}, 8'h01);
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33); rx_push(8'h44);
    rd_chk(6'h04, 8'h0F, "R3");
    chk("R10", "rx_ready full", {7'd0, rx_ready}, 8'h00);
    rx_push(8'h55);
    rd_chk(6'h14, 8'h03, "R5");
    rd_chk(6'h0C, 8'h11, "R10");
    rd_chk(6'h04, 8'h0D, "R3");
    rd_chk(6'h14, 8'h01, "R5");
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h00);
    rd_chk(6'h14, 8'h03, "R5");
    rd_chk(6'h0C, 8'h22, "R10");
    rd_chk(6'h0C, 8'h33, "R10");
    rd_chk(6'h0C, 8'h44, "R10");
    rd_chk(6'h0C, 8'h00, "R10");
    rd_chk(6'h04, 8'h0C, "R10");
    rx_push(8'h61); rx_push(8'h62);
    wr(6'h08, 8'h21);
    rd_chk(6'h04, 8'h0C, "R7");
    chk("R8", "rx re-enabled", {7'd0, rx_ready}, 8'h01);
    wr(6'h08, 8'h02);
    chk("R8", "rx disabled", {7'd0, rx_ready}, 8'h00);
  endtask

  task automatic t_break();
    brk_pulse();
    rd_chk(6'h04, 8'h0D, "R11");
    rd_chk(6'h14, 8'h07, "R11");
    rd_chk(6'h0C, 8'h00, "R11");
    wr(6'h14, 8'h04);
    chk("R6", "irq on break", {7'd0, irq}, 8'h01);
    wr(6'h08, 8'h40);
    chk("R7", "irq misc4", {7'd0, irq}, 8'h01);
    wr(6'h08, 8'h50);
    rd_chk(6'h14, 8'h01, "R7");
    chk("R7", "irq after ack", {7'd0, irq}, 8'h00);
    wr(6'h08, 8'h01);
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3); rx_push(8'hA4);
    brk_pulse();
    rd_chk(6'h04, 8'h0F, "R11");
    rd_chk(6'h0C, 8'hA1, "R11");
    rd_chk(6'h0C, 8'hA2, "R11");
    rd_chk(6'h0C, 8'hA3, "R11");
    rd_chk(6'h0C, 8'h00, "R11");
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hB7; rx_break = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0;
    rd_chk(6'h0C, 8'h00, "R11");
    rd_chk(6'h0C, 8'h00, "R11");
    rd_chk(6'h04, 8'h0C, "R11");
    wr(6'h08, 8'h50);
    wr(6'h14, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_ptr();
    t_map();
    t_tx();
    t_rx();
    t_break();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule